// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block sits on the host side of a three-wire serial link to a voltage-output DAC. Upstream logic hands it a 12-bit output code and a 2-bit power mode over a valid/ready handshake. The block packs them into a 16-bit word and shifts the word out MSB first. It drives a frame-select line, a serial clock derived from the system clock, and a data line.

The target latches data on falling serial-clock edges. The writer therefore moves the data line only when the clock rises, and it holds the clock low when a frame opens. Each frame opens with frame select held high for a programmed number of system cycles. Its falling edge starts the write. Sixteen falling clock edges follow, then frame select goes high again for the same number of cycles. After that the link returns to an idle state in which all three lines sit low. An abort input raises frame select in the middle of a frame, which makes the target discard the write. It exists to exercise that cancel path.

Top module: `dac_frame_writer`

## Requirements
- R1: A frame carries 16 bits MSB first. Bits 15:14 are sent as 0, bits 13:12 carry the mode and bits 11:0 carry the code.
- R2: While frame select is low, the data line changes only in the sample where the serial clock rises. Its value is the same just before and just after every falling edge.
- R3: Inside a frame, every high and every low phase of the serial clock lasts exactly HALF_DIV system cycles. The first rise comes HALF_DIV cycles after frame select falls.
- R4: Before each frame, frame select is high for exactly GAP_CYC cycles, then falls.
- R5: A complete frame has exactly 16 falling clock edges while frame select is low. Frame select rises HALF_DIV cycles after the 16th fall, then stays high for exactly GAP_CYC cycles.
- R6: While busy is low, frame select, serial clock and data are all low.
- R7: in_ready is high exactly when the writer is idle. A word is taken when in_valid and in_ready are both high, and busy is high in the following cycle.
- R8: done is a single-cycle pulse in the cycle frame select returns low after a frame, and busy drops in that same cycle. It occurs at no other time.
- R9: abort asserted during the shift phase raises frame select in the next cycle, before the 16th fall. A trailing gap of GAP_CYC cycles and a done pulse still follow. abort has no effect while the writer is idle or while frame select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Writer can take a word |
| in_code | input | 12 | DAC output code |
| in_mode | input | 2 | Power mode field |
| abort | input | 1 | Cancel the frame in flight |
| sync_o | output | 1 | Frame select to the DAC |
| sclk_o | output | 1 | Serial clock to the DAC |
| sdata_o | output | 1 | Serial data to the DAC |
| busy | output | 1 | A frame or its gaps are in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench decodes the three lines the way the target would. It measures every clock phase and every frame-select high run. It collects the 16 bits on falling edges and compares them with a frame it packs arithmetically. If data were moved on the falling edge, the captured word would be shifted by one bit. If the last low phase were dropped, frame select would rise together with the 16th fall. A wrong gap count shows up as a high run of the wrong length.

Aborts are placed at random points of the shift phase, and also in idle. A writer that ignored abort would complete a word the bench does not expect. A writer that still fired the 16th fall would be caught by the edge count. The bench also holds the next word on the handshake while a frame is running, so an early accept would show up as a frame out of order.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  localparam int CODE_W  = 12;
  localparam int MODE_W  = 2;
  localparam int PAD_W   = 2;
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } wr_state_t;

  // Zero pad on top, then mode, then code; MSB leaves first.
  function automatic logic [FRAME_W-1:0] pack_word(
      input logic [MODE_W-1:0] mode, input logic [CODE_W-1:0] code);
    return {{PAD_W{1'b0}}, mode, code};
  endfunction
endpackage

// File: rtl/dac_tick_timer.sv
module dac_tick_timer #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || expire)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [W-1:0]                frame_in,
  input  logic                        shift_en,
  input  logic                        fall_en,
  output logic                        msb_o,
  output logic                        last_fall_o,
  output logic [$clog2(W+1)-1:0]      falls_o
);
  localparam int NW = $clog2(W + 1);

  logic [W-1:0]  sr;
  logic [NW-1:0] falls;

  assign msb_o       = sr[W-1];
  assign falls_o     = falls;
  assign last_fall_o = (falls == NW'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      falls <= '0;
    end else if (load) begin
      sr    <= frame_in;
      falls <= '0;
    end else begin
      if (shift_en) sr    <= {sr[W-2:0], 1'b0};
      if (fall_en)  falls <= falls + 1'b1;
    end
  end

  // The fall counter never passes the frame length.
  assert_fall_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    falls <= NW'(W));
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
  import dac_wr_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              abort,
  output logic              sync_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              busy,
  output logic              done
);
  localparam int NW = $clog2(FRAME_W + 1);

  wr_state_t state, state_nx;
  logic sync_q, sclk_q, shift_q, done_q;
  logic half_tick, gap_tick;
  logic msb, last_fall;
  logic [NW-1:0] falls;

  // Named events for the assertions.
  logic accept, rise_ev, fall_ev, end_ev, abort_ev;

  dac_tick_timer #(.LIMIT(HALF_DIV)) u_half (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT), .expire(half_tick));

  dac_tick_timer #(.LIMIT(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .run((state == ST_LEAD) || (state == ST_TAIL)), .expire(gap_tick));

  dac_frame_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .frame_in(pack_word(in_mode, in_code)),
    .shift_en(rise_ev && (falls != '0)), .fall_en(fall_ev),
    .msb_o(msb), .last_fall_o(last_fall), .falls_o(falls));

  assign accept   = in_valid && (state == ST_IDLE);
  assign abort_ev = abort && (state == ST_SHIFT);
  assign rise_ev  = (state == ST_SHIFT) && half_tick && !sclk_q && !last_fall && !abort;
  assign fall_ev  = (state == ST_SHIFT) && half_tick &&  sclk_q && !abort;
  assign end_ev   = (state == ST_SHIFT) && half_tick && !sclk_q &&  last_fall;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept)            state_nx = ST_LEAD;
      ST_LEAD:  if (gap_tick)          state_nx = ST_SHIFT;
      ST_SHIFT: if (abort_ev || end_ev) state_nx = ST_TAIL;
      ST_TAIL:  if (gap_tick)          state_nx = ST_IDLE;
      default:                         state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sync_q  <= 1'b0;
      shift_q <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state   <= state_nx;
      sync_q  <= (state_nx == ST_LEAD) || (state_nx == ST_TAIL);
      shift_q <= (state_nx == ST_SHIFT);
      done_q  <= (state == ST_TAIL) && gap_tick;
      if (rise_ev)               sclk_q <= 1'b1;
      else if (fall_ev)          sclk_q <= 1'b0;
      else if (state == ST_TAIL) sclk_q <= 1'b0;
    end
  end

  assign sync_o   = sync_q;
  assign sclk_o   = sclk_q;
  assign sdata_o  = shift_q & msb;
  assign busy     = (state != ST_IDLE);
  assign in_ready = (state == ST_IDLE);
  assign done     = done_q;

  assert_rise_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> !sync_o);
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $stable(sdata_o));
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sync_o && !sclk_o && !sdata_o));
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_abort_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> sync_o);
endmodule

// File: tb/sim_dac_frame_writer.sv
module sim_dac_frame_writer;
  localparam int HALF = 2;
  localparam int GAP  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [11:0] in_code = '0;
  logic [1:0] in_mode = '0;
  logic abort = 1'b0;
  logic in_ready, sync_o, sclk_o, sdata_o, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int exp_word [0:255];
  bit exp_ab   [0:255];
  int wi = 0;
  int ri = 0;

  always #10 clk = ~clk;

  dac_frame_writer #(.HALF_DIV(HALF), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_mode(in_mode), .abort(abort),
    .sync_o(sync_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bench_frame(input int mode, input int code);
    return mode * 4096 + code;
  endfunction

  // Line decoder, sampled at falling system-clock edges.
  int phase = 0;
  int hi_run = 0;
  int edge_cnt = 0;
  int nf = 0;
  int word = 0;
  logic p_sync = 0, p_sclk = 0, p_data = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit tail_end;
      tail_end = 0;
      edge_cnt++;
      if (!busy) chk(!sync_o && !sclk_o && !sdata_o, "R6", {sync_o, sclk_o, sdata_o}, 0);
      if (sync_o && !p_sync) begin
        hi_run = 0;
        if (phase == 0) phase = 1;
        else if (phase == 2) begin
          chk(ri < wi, "R7", ri, wi);
          if (ri < wi) begin
            if (exp_ab[ri]) chk(nf < 16, "R9", nf, 15);
            else begin
              chk(nf == 16, "R5", nf, 16);
              chk(word == exp_word[ri], "R1", word, exp_word[ri]);
              chk(edge_cnt == HALF, "R5", edge_cnt, HALF);
            end
            ri++;
          end
          phase = 3;
        end
      end
      if (sync_o) hi_run++;
      if (!sync_o && p_sync) begin
        chk(hi_run == GAP, (phase == 1) ? "R4" : "R5", hi_run, GAP);
        if (phase == 1) begin
          phase = 2; nf = 0; word = 0; edge_cnt = 0;
        end else if (phase == 3) begin
          tail_end = 1;
          chk(done && !busy, "R8", {done, busy}, 2);
          phase = 0;
        end
      end else if (phase == 2 && !sync_o) begin
        if (sclk_o && !p_sclk) begin
          chk(edge_cnt == HALF, "R3", edge_cnt, HALF);
          edge_cnt = 0;
        end else if (!sclk_o && p_sclk) begin
          chk(edge_cnt == HALF, "R3", edge_cnt, HALF);
          chk(sdata_o == p_data, "R2", sdata_o, p_data);
          word = (word << 1) | int'(p_data);
          nf++;
          edge_cnt = 0;
        end else if (sdata_o != p_data) begin
          chk(0, "R2", sdata_o, p_data);
        end
      end
      if (done && !tail_end) chk(0, "R8", 1, 0);
      p_sync = sync_o; p_sclk = sclk_o; p_data = sdata_o;
    end
  end

  task automatic send(input logic [1:0] m, input logic [11:0] c, input int ab_after);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_code = c;
    while (!in_ready) @(negedge clk);
    exp_word[wi] = bench_frame(int'(m), int'(c));
    exp_ab[wi] = (ab_after > 0);
    wi++;
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy && !in_ready, "R7", {busy, in_ready}, 2);
    if (ab_after > 0) begin
      repeat (ab_after - 1) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(sync_o == 1'b1, "R9", sync_o, 1);
    end
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sync_o && !sclk_o && !sdata_o && !done && !busy, "R6", {sync_o, sclk_o, sdata_o}, 0);
    chk(in_ready, "R7", in_ready, 1);

    // Directed corners of the field layout.
    send(2'd0, 12'h000, 0);
    send(2'd3, 12'hFFF, 0);
    send(2'd1, 12'hA5A, 0);
    send(2'd2, 12'h801, 0);
    drain();

    // abort in idle has no effect on the lines (R9).
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    @(negedge clk);
    chk(!sync_o && !busy, "R9", {sync_o, busy}, 0);

    // Directed aborts at the first and near the last bit.
    send(2'd3, 12'h5A5, GAP + 1);
    send(2'd2, 12'h3C3, GAP + 60);
    send(2'd1, 12'h0F0, 0);

    // Random words, some cancelled mid-shift, offered back to back.
    for (int i = 0; i < 30; i++) begin
      int ab;
      ab = (($urandom % 5) == 0) ? (GAP + 1 + int'($urandom % 50)) : 0;
      send(2'($urandom), 12'($urandom), ab);
    end
    drain();

    chk(ri == wi, "R5", ri, wi);
    finish_run();
  end
endmodule